// File: doc/BRIEF.md
# Shadowed Serial Word Buffer Controller

This block connects a CPU register interface to a time-slotted serial codec shifter. It holds four transmit and four receive buffer words that the CPU accesses, plus a shadow copy of each on the serial side. On every serviced slot the shifter pulses a word strobe. The block then takes the received word into the receive shadow at the current slot index and presents the transmit shadow word for that index. Buffer *i* always serves the *i*-th serviced slot after a boundary, whatever the frame layout is.

A 2-bit length setting selects how many words, from one to four, pass between two transfer events. When the strobe arrives with the slot index equal to the length setting, the index returns to zero and a transfer event takes place. At that point the receive shadows, including the word arriving in that cycle, move into the receive buffers, and the transmit buffers move into the transmit shadows. An interrupt pulse is raised, and four status flags (transmit empty, transmit underflow, receive full, receive overflow) are updated. The flags are tracked per location and only locations below the selected length take part. The current slot index is exposed so that software can resynchronise after losing track.

Top module: `swbuf_ctrl`

## Requirements
- R1: With `cfg_len` = n, the slot index `slot_idx` advances by one on each `slot_stb` and returns to 0 on the strobe that arrives while it equals n, so n+1 slots are served between transfer events.
- R2: A transfer event copies every transmit buffer into its transmit shadow. It also copies every receive shadow into its receive buffer, and this includes the `rx_word` taken in the same cycle. `tx_word` always shows the transmit shadow selected by `slot_idx`.
- R3: `irq` is high for exactly the one cycle after each strobe that causes a transfer event, and low otherwise.
- R4: `tx_empty` becomes 1 at each transfer event and becomes 0 when the CPU writes an in-use transmit buffer location.
- R5: `tx_underflow` becomes 1 at a transfer event if an in-use transmit location was not written since the previous event. It stays 1 until every such location has been written.
- R6: `rx_full` becomes 1 at each transfer event and returns to 0 only once every in-use receive location has been read.
- R7: A transfer event that overwrites an in-use receive location that has not been read sets `rx_overflow`, and the new data replaces the old. Reading that location clears the overflow for it.
- R8: Locations with an index greater than `cfg_len` never change any flag when they are written or read.
- R9: When a CPU write lands in the same cycle as a transfer event, the shadow receives the old buffer content and the write then updates the buffer. The write's flag effects (clearing `tx_empty` and the underflow of that location) apply after the event's effects.
- R10: When a CPU read lands in the same cycle as a transfer event, it returns the newly copied word and clears that location's unread and overflow state after the event has set them.
- R11: Synchronous reset `rst` clears all words, the slot index, `irq`, `cpu_rdata` and every flag, except `tx_empty`, which resets to 1.
- R12: `cpu_rdata` shows, one cycle after `cpu_rd`, the receive buffer word addressed by `cpu_raddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_len | input | 2 | Words per transfer minus one |
| cpu_wr | input | 1 | CPU transmit buffer write strobe |
| cpu_waddr | input | 2 | Transmit buffer index for the write |
| cpu_wdata | input | 16 | Write data |
| cpu_rd | input | 1 | CPU receive buffer read strobe |
| cpu_raddr | input | 2 | Receive buffer index for the read |
| cpu_rdata | output | 16 | Registered read data |
| slot_stb | input | 1 | One pulse per serviced serial slot |
| rx_word | input | 16 | Word received in the current slot |
| tx_word | output | 16 | Transmit shadow word for the current slot |
| slot_idx | output | 2 | Current slot index |
| irq | output | 1 | One-cycle transfer event pulse |
| tx_empty | output | 1 | Transmit buffers may be written |
| tx_underflow | output | 1 | An in-use transmit location missed its refill |
| rx_full | output | 1 | New receive data present |
| rx_overflow | output | 1 | An unread receive location was overwritten |

## Verification
A CPU buffer access can fall in the same cycle as the boundary strobe that triggers a transfer event. The bench provokes this with a one-word length, so that every strobe is a boundary, and drives the strobe together with a write, and later together with a read. It judges the write case by the word the next strobe presents (the old content) and the one after it (the new content), and by the flags. It judges the read case by the returned word being the freshly copied one, with full and overflow both cleared.

// File: rtl/swbuf_pkg.sv
package swbuf_pkg;
    localparam int unsigned SWB_DATA_W = 16;
    localparam int unsigned SWB_WORDS  = 4;
endpackage

// File: rtl/swbuf_slot_ctr.sv
module swbuf_slot_ctr #(
    parameter int unsigned IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic [IDX_W-1:0] len,
    output logic [IDX_W-1:0] idx,
    output logic             copy_evt,
    output logic             irq
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             irq;
    } ctr_t;

    ctr_t st_d, st_q;

    assign copy_evt = stb && (st_q.idx == len);

    always_comb begin
        st_d     = st_q;
        st_d.irq = copy_evt;
        if (copy_evt) begin
            st_d.idx = '0;
        end else if (stb) begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx = st_q.idx;
    assign irq = st_q.irq;
endmodule

// File: rtl/swbuf_tx_path.sv
module swbuf_tx_path #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              copy_evt,
    input  logic [WORDS-1:0]  use_mask,
    input  logic [IDX_W-1:0]  slot_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] tx_word,
    output logic              empty,
    output logic              underflow
);
    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] hold;
        logic [WORDS-1:0][DATA_W-1:0] shad;
        logic [WORDS-1:0]             written;
        logic [WORDS-1:0]             udf;
        logic                         empty;
    } tx_t;

    tx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // transfer event first
        if (copy_evt) begin
            st_d.shad    = st_q.hold;
            st_d.udf     = use_mask & ~st_q.written;
            st_d.written = '0;
            st_d.empty   = 1'b1;
        end
        // CPU write applies on top of the event
        if (wr_en) begin
            st_d.hold[wr_addr]    = wr_data;
            st_d.written[wr_addr] = 1'b1;
            if (use_mask[wr_addr]) begin
                st_d.udf[wr_addr] = 1'b0;
                st_d.empty        = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_word   = st_q.shad[slot_idx];
    assign empty     = st_q.empty;
    assign underflow = |st_q.udf;
endmodule

// File: rtl/swbuf_rx_path.sv
module swbuf_rx_path #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              copy_evt,
    input  logic [WORDS-1:0]  use_mask,
    input  logic [IDX_W-1:0]  slot_idx,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              overflow
);
    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] hold;
        logic [WORDS-1:0][DATA_W-1:0] shad;
        logic [WORDS-1:0]             unread;
        logic [WORDS-1:0]             ovf;
        logic [DATA_W-1:0]            rdata;
    } rx_t;

    rx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb) begin
            st_d.shad[slot_idx] = rx_word;
        end
        // transfer event includes the word arriving this cycle
        if (copy_evt) begin
            st_d.hold   = st_d.shad;
            st_d.ovf    = st_q.ovf | (use_mask & st_q.unread);
            st_d.unread = use_mask;
        end
        // CPU read sees the post-event contents
        if (rd_en) begin
            st_d.unread[rd_addr] = 1'b0;
            st_d.ovf[rd_addr]    = 1'b0;
            st_d.rdata           = st_d.hold[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rdata;
    assign full     = |st_q.unread;
    assign overflow = |st_q.ovf;
endmodule

// File: rtl/swbuf_ctrl.sv
module swbuf_ctrl
    import swbuf_pkg::*;
#(
    parameter int unsigned DATA_W = SWB_DATA_W,
    parameter int unsigned WORDS  = SWB_WORDS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(WORDS)-1:0]   cfg_len,
    input  logic                       cpu_wr,
    input  logic [$clog2(WORDS)-1:0]   cpu_waddr,
    input  logic [DATA_W-1:0]          cpu_wdata,
    input  logic                       cpu_rd,
    input  logic [$clog2(WORDS)-1:0]   cpu_raddr,
    output logic [DATA_W-1:0]          cpu_rdata,
    input  logic                       slot_stb,
    input  logic [DATA_W-1:0]          rx_word,
    output logic [DATA_W-1:0]          tx_word,
    output logic [$clog2(WORDS)-1:0]   slot_idx,
    output logic                       irq,
    output logic                       tx_empty,
    output logic                       tx_underflow,
    output logic                       rx_full,
    output logic                       rx_overflow
);
    localparam int unsigned IDX_W = $clog2(WORDS);

    logic [WORDS-1:0] use_mask;
    logic             copy_evt;

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_mask
        assign use_mask[gi] = (IDX_W'(gi) <= cfg_len);
    end

    swbuf_slot_ctr #(.IDX_W(IDX_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .stb      (slot_stb),
        .len      (cfg_len),
        .idx      (slot_idx),
        .copy_evt (copy_evt),
        .irq      (irq)
    );

    swbuf_tx_path #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .copy_evt  (copy_evt),
        .use_mask  (use_mask),
        .slot_idx  (slot_idx),
        .wr_en     (cpu_wr),
        .wr_addr   (cpu_waddr),
        .wr_data   (cpu_wdata),
        .tx_word   (tx_word),
        .empty     (tx_empty),
        .underflow (tx_underflow)
    );

    swbuf_rx_path #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .stb      (slot_stb),
        .copy_evt (copy_evt),
        .use_mask (use_mask),
        .slot_idx (slot_idx),
        .rx_word  (rx_word),
        .rd_en    (cpu_rd),
        .rd_addr  (cpu_raddr),
        .rd_data  (cpu_rdata),
        .full     (rx_full),
        .overflow (rx_overflow)
    );
endmodule

// File: rtl/swbuf_ctrl_chk.sv
module swbuf_ctrl_chk #(
    parameter int unsigned IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] cfg_len,
    input logic             slot_stb,
    input logic [IDX_W-1:0] slot_idx,
    input logic             cpu_wr,
    input logic [IDX_W-1:0] cpu_waddr,
    input logic             cpu_rd,
    input logic             irq,
    input logic             tx_empty,
    input logic             tx_underflow,
    input logic             rx_full,
    input logic             rx_overflow
);
    logic boundary;
    assign boundary = slot_stb && (slot_idx == cfg_len);

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (slot_idx == '0)); // R1
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (slot_stb && !boundary) |=> (slot_idx == $past(slot_idx) + 1'b1)); // R1
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !slot_stb |=> $stable(slot_idx)); // R1
    AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        boundary |=> irq); // R3
    AST_IRQ_ONLY_EVENT: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> !irq); // R3
    AST_EMPTY_AT_EVENT: assert property (@(posedge clk) disable iff (rst)
        (boundary && !(cpu_wr && cpu_waddr <= cfg_len)) |=> tx_empty); // R4
    AST_EMPTY_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_empty) |-> irq); // R4
    AST_UNDERFLOW_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_underflow) |-> irq); // R5
    AST_FULL_AT_EVENT: assert property (@(posedge clk) disable iff (rst)
        (boundary && !(cpu_rd && cfg_len == '0)) |=> rx_full); // R6
    AST_OVERFLOW_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overflow) |-> irq); // R7
endmodule

bind swbuf_ctrl swbuf_ctrl_chk #(.IDX_W($clog2(WORDS))) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_len      (cfg_len),
    .slot_stb     (slot_stb),
    .slot_idx     (slot_idx),
    .cpu_wr       (cpu_wr),
    .cpu_waddr    (cpu_waddr),
    .cpu_rd       (cpu_rd),
    .irq          (irq),
    .tx_empty     (tx_empty),
    .tx_underflow (tx_underflow),
    .rx_full      (rx_full),
    .rx_overflow  (rx_overflow)
);

// File: tb/sim_swbuf_ctrl.sv
`timescale 1ns/1ps
module sim_swbuf_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_len;
    logic        cpu_wr;
    logic [1:0]  cpu_waddr;
    logic [15:0] cpu_wdata;
    logic        cpu_rd;
    logic [1:0]  cpu_raddr;
    logic [15:0] cpu_rdata;
    logic        slot_stb;
    logic [15:0] rx_word;
    logic [15:0] tx_word;
    logic [1:0]  slot_idx;
    logic        irq, tx_empty, tx_underflow, rx_full, rx_overflow;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    swbuf_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_len(cfg_len),
        .cpu_wr(cpu_wr), .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_raddr(cpu_raddr), .cpu_rdata(cpu_rdata),
        .slot_stb(slot_stb), .rx_word(rx_word), .tx_word(tx_word),
        .slot_idx(slot_idx), .irq(irq), .tx_empty(tx_empty),
        .tx_underflow(tx_underflow), .rx_full(rx_full), .rx_overflow(rx_overflow)
    );

    // op codes
    localparam logic [2:0] OP_IDLE = 3'd0, OP_WR = 3'd1, OP_RD = 3'd2,
                           OP_STB = 3'd3, OP_LEN = 3'd4;
    // {op, addr, data, flags{irq,empty,udf,full,ovf}, idx, chk, word}
    localparam int NV = 19;
    localparam logic [44:0] TBL [NV] = '{
        {OP_WR,   2'd0, 16'hA0A0, 5'b00000, 2'd0, 1'b0, 16'h0000},
        {OP_WR,   2'd1, 16'hB1B1, 5'b00000, 2'd0, 1'b0, 16'h0000},
        {OP_STB,  2'd0, 16'h1111, 5'b00000, 2'd1, 1'b1, 16'h0000},
        {OP_STB,  2'd0, 16'h2222, 5'b11010, 2'd0, 1'b1, 16'h0000},
        {OP_IDLE, 2'd0, 16'h0000, 5'b01010, 2'd0, 1'b0, 16'h0000},
        {OP_STB,  2'd0, 16'h3333, 5'b01010, 2'd1, 1'b1, 16'hA0A0},
        {OP_RD,   2'd0, 16'h0000, 5'b01010, 2'd1, 1'b1, 16'h1111},
        {OP_STB,  2'd0, 16'h4444, 5'b11111, 2'd0, 1'b1, 16'hB1B1},
        {OP_RD,   2'd1, 16'h0000, 5'b01110, 2'd0, 1'b1, 16'h4444},
        {OP_WR,   2'd1, 16'hC2C2, 5'b00110, 2'd0, 1'b0, 16'h0000},
        {OP_WR,   2'd0, 16'hD3D3, 5'b00010, 2'd0, 1'b0, 16'h0000},
        {OP_RD,   2'd0, 16'h0000, 5'b00000, 2'd0, 1'b1, 16'h3333},
        {OP_LEN,  2'd0, 16'h0003, 5'b00000, 2'd0, 1'b0, 16'h0000},
        {OP_STB,  2'd0, 16'h5555, 5'b00000, 2'd1, 1'b1, 16'hA0A0},
        {OP_STB,  2'd0, 16'h6666, 5'b00000, 2'd2, 1'b1, 16'hB1B1},
        {OP_STB,  2'd0, 16'h7777, 5'b00000, 2'd3, 1'b1, 16'h0000},
        {OP_STB,  2'd0, 16'h8888, 5'b11110, 2'd0, 1'b1, 16'h0000},
        {OP_RD,   2'd3, 16'h0000, 5'b01110, 2'd0, 1'b1, 16'h8888},
        {OP_STB,  2'd0, 16'h9999, 5'b01110, 2'd1, 1'b1, 16'hD3D3}
    };

    function automatic logic [4:0] flags();
        return {irq, tx_empty, tx_underflow, rx_full, rx_overflow};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] len);
        @(negedge clk);
        rst = 1'b1; cfg_len = len;
        cpu_wr = 0; cpu_rd = 0; slot_stb = 0;
        cpu_waddr = 0; cpu_raddr = 0; cpu_wdata = 0; rx_word = 0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // one cycle of stimulus; tx_word is checked while the strobe is applied
    task automatic cyc(input logic wr, input logic [1:0] wa, input logic [15:0] wd,
                       input logic rd, input logic [1:0] ra,
                       input logic stb, input logic [15:0] rw,
                       input logic chk_tx, input logic [15:0] exp_tx, input string req_tx);
        @(negedge clk);
        cpu_wr = wr; cpu_waddr = wa; cpu_wdata = wd;
        cpu_rd = rd; cpu_raddr = ra; slot_stb = stb; rx_word = rw;
        #0.5;
        if (chk_tx) check(req_tx, tx_word, exp_tx);
        @(posedge clk);
        #1;
        cpu_wr = 0; cpu_rd = 0; slot_stb = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        do_reset(2'd1);
        // R11 reset state
        check("R11 flags", {11'd0, flags()}, {11'd0, 5'b01000});
        check("R11 slot_idx", {14'd0, slot_idx}, 16'd0);
        check("R11 tx_word", tx_word, 16'h0000);
        check("R11 cpu_rdata", cpu_rdata, 16'h0000);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [2:0] op;
            logic [1:0] ad;
            logic [15:0] dt, wd;
            logic [4:0] fl;
            logic [1:0] ix;
            logic ck;
            {op, ad, dt, fl, ix, ck, wd} = TBL[i];
            case (op)
                OP_WR:  cyc(1, ad, dt, 0, 0, 0, 0, 0, 0, "");
                OP_RD:  cyc(0, 0, 0, 1, ad, 0, 0, 0, 0, "");
                OP_STB: cyc(0, 0, 0, 0, 0, 1, dt, ck, wd, "R2 tx_word");
                OP_LEN: begin cfg_len = dt[1:0]; cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, ""); end
                default: cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
            endcase
            check("R3/R4/R5/R6/R7 flags", {11'd0, flags()}, {11'd0, fl});
            check("R1 slot_idx", {14'd0, slot_idx}, {14'd0, ix});
            if (op == OP_RD) check("R12 cpu_rdata", cpu_rdata, wd);
        end

        // single-word length: out-of-use locations (R8) and overwrite (R7)
        do_reset(2'd0);
        cyc(0, 0, 0, 0, 0, 1, 16'h1234, 1, 16'h0000, "R2 tx_word");
        check("R5 underflow at event", {11'd0, flags()}, {11'd0, 5'b11110});
        cyc(1, 2'd2, 16'h5A5A, 0, 0, 0, 0, 0, 0, "");
        check("R8 write beyond length", {11'd0, flags()}, {11'd0, 5'b01110});
        cyc(0, 0, 0, 1, 2'd3, 0, 0, 0, 0, "");
        check("R8 read beyond length", {11'd0, flags()}, {11'd0, 5'b01110});
        cyc(0, 0, 0, 0, 0, 1, 16'h5678, 1, 16'h0000, "R2 tx_word");
        check("R7 overflow set", {11'd0, flags()}, {11'd0, 5'b11111});
        cyc(0, 0, 0, 1, 2'd0, 0, 0, 0, 0, "");
        check("R7 overwritten data", cpu_rdata, 16'h5678);
        check("R7 overflow cleared by read", {11'd0, flags()}, {11'd0, 5'b01100});
        cyc(1, 2'd0, 16'h0F0F, 0, 0, 0, 0, 0, 0, "");
        check("R4 empty cleared by write", {11'd0, flags()}, {11'd0, 5'b00000});

        // write in the event cycle (R9)
        cyc(1, 2'd0, 16'hEEEE, 0, 0, 1, 16'hAAAA, 1, 16'h0000, "R2 tx_word");
        check("R9 flags after write+event", {11'd0, flags()}, {11'd0, 5'b10010});
        // read in the event cycle (R10); shadow holds pre-write content (R9)
        cyc(0, 0, 0, 1, 2'd0, 1, 16'h4321, 1, 16'h0F0F, "R9 shadow took old word");
        check("R10 read returns new word", cpu_rdata, 16'h4321);
        check("R10 flags after read+event", {11'd0, flags()}, {11'd0, 5'b11000});
        cyc(0, 0, 0, 0, 0, 1, 16'h0000, 1, 16'hEEEE, "R9 write landed in buffer");
        check("R9 flags next event", {11'd0, flags()}, {11'd0, 5'b11110});

        // three-word length (R1)
        do_reset(2'd2);
        cyc(0, 0, 0, 0, 0, 1, 16'h0001, 0, 0, "");
        check("R1 len2 first strobe", {9'd0, slot_idx, flags()}, {9'd0, 2'd1, 5'b01000});
        cyc(0, 0, 0, 0, 0, 1, 16'h0002, 0, 0, "");
        check("R1 len2 second strobe", {9'd0, slot_idx, flags()}, {9'd0, 2'd2, 5'b01000});
        cyc(0, 0, 0, 0, 0, 1, 16'h0003, 0, 0, "");
        check("R1 len2 boundary", {9'd0, slot_idx, flags()}, {9'd0, 2'd0, 5'b11110});
        cyc(0, 0, 0, 1, 2'd2, 0, 0, 0, 0, "");
        check("R2 word arriving at boundary copied", cpu_rdata, 16'h0003);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule